// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a two-wire serial memory. It holds 512 bytes. A system clock oversamples the bus clock and data lines. The block finds start and stop conditions and compares the device address byte against a fixed type code and two strap pins. It then acknowledges bytes by pulling the data line low through an open-drain enable.

A master writes one byte per transaction. It sends the device address with the write flag, then a word address byte, then one data byte. The stop that closes the transaction starts an internal rewrite window. The window is timed by a counter. The array takes the new byte when the window ends. While the window runs, every matching address byte gets no acknowledge, so the master can poll for completion.

Reads come in three forms: random, sequential and current address. A read ends when the master answers a byte with a high acknowledge. A write-protect input guards the upper half of the array and leaves reads unaffected.

Top module: `twi_eeprom_slave`

## Requirements
- R1: While reset is asserted and right after it is released, the block does not drive SDA (sda_oe_o = 0).
- R2: The device address byte is sent MSB first as bits 7..4 = 1010, bit 3 = A2 strap, bit 2 = A1 strap, bit 1 = page bit (ninth word address bit), bit 0 = R/W (1 = read). If bits 7..2 do not match, the byte gets no acknowledge and later bytes are ignored until the next start.
- R3: A write transaction is device byte (R/W = 0), word address byte, data byte, stop. Each of the three bytes is acknowledged. The target address is {page bit, word address byte}. The data is in the array once the rewrite window ends.
- R4: The rewrite window starts at the stop that follows an accepted data byte and lasts BUSY_CYCLES system clocks (default 5000). During the window a matching device byte with either R/W value gets no acknowledge. After the window it is acknowledged.
- R5: With wp_i high, a data byte aimed at 100h..1FFh is still acknowledged, but the array is unchanged and no rewrite window starts.
- R6: With wp_i high, writes to 000h..0FFh proceed normally.
- R7: Raising wp_i after the rewrite window has started does not cancel the write.
- R8: Random read: a write-mode device byte and a word address byte, then a repeated start and a read-mode device byte, return the byte at that address. This holds at any wp_i level.
- R9: Sequential read: each low acknowledge from the master returns the next address. Address 1FFh is followed by 000h.
- R10: Current address read: a read-mode device byte alone returns the byte after the last one read or written. The page bit of that device byte is ignored.
- R11: After the master answers a read byte with a high acknowledge, the block releases SDA so that the master can issue a stop.
- R12: A write carries one data byte. A second data byte in the same transaction gets no acknowledge and does not change the array.
- R13: A start or stop in the middle of a byte abandons the transaction in progress. A stop of this kind starts no rewrite window, and the next transaction is decoded from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_o | output | 1 | Data output value, always 0 (open drain) |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| wp_i | input | 1 | Write protect for the upper half of the array |
| a2_i | input | 1 | Device address strap, bit 3 of the device byte |
| a1_i | input | 1 | Device address strap, bit 2 of the device byte |

## Verification
The checks on the SDA enable assume the master behaves well. It moves SDA only while SCL is low, and it never issues a start or stop while the slave holds the line. With that, any change of the slave's drive lands in a low SCL phase. Each SCL phase lasts eight system clocks, and the bench master changes its data line four clocks into the low phase. The synchronized clock edge therefore always comes before the synchronized data edge. The rewrite window is only probed with polls placed well before and well after its end, so that polls never meet a window boundary mid-byte.

// File: rtl/twe_pkg.sv
package twe_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ACK_DEV,
    ST_WADDR,
    ST_ACK_WADDR,
    ST_WDATA,
    ST_ACK_WDATA,
    ST_RD,
    ST_RACK,
    ST_SKIP
  } twe_state_e;
endpackage

// File: rtl/twe_bus_sync.sv
module twe_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] scl_sr, sda_sr;
  logic scl_d, sda_d, scl_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[MSB-1:0], scl_i};
      sda_sr <= {sda_sr[MSB-1:0], sda_i};
      scl_d  <= scl_sr[MSB];
      sda_d  <= sda_sr[MSB];
    end
  end

  assign scl_s      = scl_sr[MSB];
  assign sda_s_o    = sda_sr[MSB];
  assign scl_rise_o = scl_s & ~scl_d;
  assign scl_fall_o = ~scl_s & scl_d;
  assign start_o    = scl_s & scl_d & sda_d & ~sda_s_o;
  assign stop_o     = scl_s & scl_d & ~sda_d & sda_s_o;
endmodule

// File: rtl/twe_mem.sv
module twe_mem #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/twe_busy_timer.sv
module twe_busy_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= CW'(CYCLES - 1);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave #(
  parameter int ADDR_W      = 9,
  parameter int BUSY_CYCLES = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic sda_oe_o,
  input  logic wp_i,
  input  logic a2_i,
  input  logic a1_i
);
  import twe_pkg::*;

  localparam int BW = BYTE_W;
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BW);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy, mem_we;
  logic [BW-1:0] mem_rdata;

  twe_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BW-1:0]     shreg_q, tx_q, wr_data_q;
  logic [ADDR_W-1:0] addr_q, wr_addr_q;
  logic              sda_drv_q, rw_q, page_q, mack_q, wr_pend_q;
  logic              dev_match, byte_done, wr_blocked, dev_ack_phase;

  twe_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  twe_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(stop_det & wr_pend_q),
    .busy_o(busy), .done_o(mem_we)
  );

  twe_mem #(.ADDR_W(ADDR_W), .DATA_W(BW)) u_mem (
    .clk_i, .we_i(mem_we), .waddr_i(wr_addr_q), .wdata_i(wr_data_q),
    .raddr_i(addr_q), .rdata_o(mem_rdata)
  );

  assign dev_match  = (shreg_q[7:4] == DEV_TYPE) && (shreg_q[3] == a2_i) && (shreg_q[2] == a1_i);
  assign byte_done  = (bit_cnt_q == LAST_BIT);
  assign wr_blocked = wp_i && addr_q[ADDR_W-1];
  assign dev_ack_phase = (state_q == ST_ACK_DEV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      tx_q      <= '0;
      wr_data_q <= '0;
      addr_q    <= '0;
      wr_addr_q <= '0;
      sda_drv_q <= 1'b0;
      rw_q      <= 1'b0;
      page_q    <= 1'b0;
      mack_q    <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_DEV;
      bit_cnt_q <= '0;
      sda_drv_q <= 1'b0;
    end else if (stop_det) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      sda_drv_q <= 1'b0;
      wr_pend_q <= 1'b0;
    end else if (scl_rise) begin
      case (state_q)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          shreg_q   <= {shreg_q[BW-2:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        ST_RD:   bit_cnt_q <= bit_cnt_q + 1'b1;
        ST_RACK: mack_q    <= ~sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state_q)
        ST_DEV: if (byte_done) begin
          bit_cnt_q <= '0;
          if (dev_match && !busy) begin
            state_q   <= ST_ACK_DEV;
            sda_drv_q <= 1'b1;
            rw_q      <= shreg_q[0];
            page_q    <= shreg_q[1];
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_ACK_DEV: begin
          if (rw_q) begin
            state_q   <= ST_RD;
            tx_q      <= mem_rdata;
            sda_drv_q <= ~mem_rdata[BW-1];
          end else begin
            state_q   <= ST_WADDR;
            sda_drv_q <= 1'b0;
          end
        end
        ST_WADDR: if (byte_done) begin
          bit_cnt_q <= '0;
          addr_q    <= {page_q, shreg_q[ADDR_W-2:0]};
          state_q   <= ST_ACK_WADDR;
          sda_drv_q <= 1'b1;
        end
        ST_ACK_WADDR: begin
          state_q   <= ST_WDATA;
          sda_drv_q <= 1'b0;
        end
        ST_WDATA: if (byte_done) begin
          bit_cnt_q <= '0;
          if (wr_pend_q) begin
            state_q <= ST_SKIP;   // one data byte per write
          end else begin
            state_q   <= ST_ACK_WDATA;
            sda_drv_q <= 1'b1;
            addr_q    <= addr_q + 1'b1;
            if (!wr_blocked) begin
              wr_pend_q <= 1'b1;
              wr_addr_q <= addr_q;
              wr_data_q <= shreg_q;
            end
          end
        end
        ST_ACK_WDATA: begin
          state_q   <= ST_WDATA;
          sda_drv_q <= 1'b0;
        end
        ST_RD: begin
          if (byte_done) begin
            bit_cnt_q <= '0;
            sda_drv_q <= 1'b0;
            state_q   <= ST_RACK;
            addr_q    <= addr_q + 1'b1;
          end else begin
            tx_q      <= {tx_q[BW-2:0], 1'b0};
            sda_drv_q <= ~tx_q[BW-2];
          end
        end
        ST_RACK: begin
          if (mack_q) begin
            state_q   <= ST_RD;
            tx_q      <= mem_rdata;
            sda_drv_q <= ~mem_rdata[BW-1];
          end else begin
            state_q <= ST_SKIP;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_o    = 1'b0;
  assign sda_oe_o = sda_drv_q;
endmodule

// File: rtl/twi_eeprom_chk.sv
module twi_eeprom_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic busy,
  input logic mem_we,
  input logic stop_det,
  input logic wr_pend_q,
  input logic dev_ack_phase
);
  always @(negedge clk_i) begin
    // R1
    if (!rst_ni) reset_release_chk: assert (!sda_oe_o);
  end

  // R11
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);

  // R4
  busy_from_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_det));

  // R4
  poll_nack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_ack_phase |-> !busy);

  // R3
  commit_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> !busy);

  // R5
  busy_needs_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(wr_pend_q));
endmodule

bind twi_eeprom_slave twi_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
  .busy(busy), .mem_we(mem_we), .stop_det(stop_det),
  .wr_pend_q(wr_pend_q), .dev_ack_phase(dev_ack_phase)
);

// File: tb/twi_eeprom_slave_tb_top.sv
module twi_eeprom_slave_tb_top;
  localparam int BUSY = 5000;
  localparam logic STRAP_A2 = 1'b1;
  localparam logic STRAP_A1 = 1'b0;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_o, sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   total = 0, bad = 0, cyc = 0;
  logic [7:0] ref_mem [512];
  string exp_tag_q[$];
  int    exp_val_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twi_eeprom_slave #(.BUSY_CYCLES(BUSY)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_line),
    .sda_o(sda_o), .sda_oe_o(sda_oe), .wp_i(wp), .a2_i(STRAP_A2), .a1_i(STRAP_A1)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(string tag, int v);
    exp_tag_q.push_back(tag);
    exp_val_q.push_back(v);
  endtask

  task automatic observe(int act);
    if (exp_val_q.size() == 0) chk("scoreboard empty", 1, 0);
    else chk(exp_tag_q.pop_front(), act, exp_val_q.pop_front());
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; wclk(4);
    scl_m = 1'b1; wclk(4);
    s = sda_line; wclk(4);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic do_start;
    sda_m = 1'b1; wclk(4);
    scl_m = 1'b1; wclk(4);
    sda_m = 1'b0; wclk(4);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wclk(4);
    scl_m = 1'b1; wclk(4);
    sda_m = 1'b1; wclk(8);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], s);
    bit_io(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, s);
      d[i] = s;
    end
    bit_io(~give_ack, s);
  endtask

  function automatic logic [7:0] dev_byte(logic p0, logic rw);
    return {4'b1010, STRAP_A2, STRAP_A1, p0, rw};
  endfunction

  task automatic send_exp(input logic [7:0] d, input int exp_ack, input string tag);
    logic k;
    push_exp(tag, exp_ack);
    send_byte(d, k);
    observe(int'(k));
  endtask

  task automatic write_tx(input logic [8:0] a, input logic [7:0] d, input string tag);
    do_start;
    send_exp(dev_byte(a[8], 1'b0), 1, tag);
    send_exp(a[7:0], 1, tag);
    send_exp(d, 1, tag);
    do_stop;
  endtask

  task automatic poll(input logic rw, output logic ack);
    logic [7:0] d;
    do_start;
    send_byte(dev_byte(1'b0, rw), ack);
    if (ack && rw) recv_byte(1'b0, d);
    do_stop;
  endtask

  task automatic wait_ready;
    logic k;
    for (int i = 0; i < 60; i++) begin
      poll(1'b0, k);
      if (k) break;
      wclk(100);
    end
  endtask

  task automatic finish_read(input int n, input logic [8:0] a, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      push_exp(tag, int'(ref_mem[9'(a + 9'(i))]));
      recv_byte(i != n - 1, d);
      observe(int'(d));
    end
    chk("R11 sda released after master nack", int'(sda_oe), 0);
    do_stop;
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, input string tag);
    do_start;
    send_exp(dev_byte(a[8], 1'b0), 1, tag);
    send_exp(a[7:0], 1, tag);
    do_start;
    send_exp(dev_byte(a[8], 1'b1), 1, tag);
    finish_read(n, a, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic k;
    int t0;
    wclk(3);
    chk("R1 sda not driven in reset", int'(sda_oe), 0);
    wclk(5);
    rst_ni = 1'b1;
    wclk(10);
    chk("R1 sda not driven after reset", int'(sda_oe), 0);

    // R2 address mismatch: strap bit and type nibble
    do_start;
    send_exp({4'b1010, ~STRAP_A2, STRAP_A1, 2'b00}, 0, "R2 strap mismatch nack");
    send_exp(8'h00, 0, "R2 bytes ignored after mismatch");
    do_stop;
    do_start;
    send_exp({4'b1011, STRAP_A2, STRAP_A1, 2'b00}, 0, "R2 type mismatch nack");
    do_stop;

    // R3 / R4 write and busy polling
    write_tx(9'h012, 8'hA5, "R3 write acks"); ref_mem[9'h012] = 8'hA5;
    t0 = cyc;
    push_exp("R4 poll during rewrite nack (W)", 0); poll(1'b0, k); observe(int'(k));
    while (cyc < t0 + 4400) wclk(1);
    push_exp("R4 poll late in rewrite nack (R)", 0); poll(1'b1, k); observe(int'(k));
    while (cyc < t0 + 5200) wclk(1);
    push_exp("R4 poll after rewrite ack", 1); poll(1'b0, k); observe(int'(k));
    read_seq(9'h012, 1, "R3 R8 random read");

    // R5 protection of upper half
    write_tx(9'h155, 8'h11, "R5 setup write"); ref_mem[9'h155] = 8'h11; wait_ready;
    wp = 1'b1;
    write_tx(9'h155, 8'h3C, "R5 protected write still acked");
    push_exp("R5 no rewrite after protected write", 1); poll(1'b0, k); observe(int'(k));
    read_seq(9'h155, 1, "R5 R8 array unchanged, read with wp high");

    // R6 lower half writable with wp high
    write_tx(9'h0F0, 8'h77, "R6 lower write"); ref_mem[9'h0F0] = 8'h77; wait_ready;
    read_seq(9'h0F0, 1, "R6 lower readback");

    // R7 wp raised during rewrite
    wp = 1'b0;
    write_tx(9'h1AB, 8'h5E, "R7 write"); ref_mem[9'h1AB] = 8'h5E;
    wp = 1'b1;
    wait_ready;
    read_seq(9'h1AB, 1, "R7 write survived wp rise");
    wp = 1'b0;

    // R9 / R10 sequential wrap and current address
    write_tx(9'h1FF, 8'hEE, "R9 setup"); ref_mem[9'h1FF] = 8'hEE; wait_ready;
    write_tx(9'h000, 8'h01, "R9 setup"); ref_mem[9'h000] = 8'h01; wait_ready;
    write_tx(9'h001, 8'h42, "R10 setup"); ref_mem[9'h001] = 8'h42; wait_ready;
    read_seq(9'h1FF, 2, "R9 sequential wrap");
    do_start;
    send_exp(dev_byte(1'b1, 1'b1), 1, "R10 current read ack");
    finish_read(1, 9'h001, "R10 current address, page bit ignored");

    // R12 second data byte refused
    write_tx(9'h021, 8'h55, "R12 setup"); ref_mem[9'h021] = 8'h55; wait_ready;
    do_start;
    send_exp(dev_byte(1'b0, 1'b0), 1, "R12 dev");
    send_exp(8'h20, 1, "R12 addr");
    send_exp(8'h9A, 1, "R12 first data ack");
    send_exp(8'h9B, 0, "R12 second data nack");
    do_stop; ref_mem[9'h020] = 8'h9A; wait_ready;
    read_seq(9'h020, 2, "R12 only first byte stored");

    // R13 start and stop mid-byte
    do_start;
    for (int i = 0; i < 4; i++) bit_io(i[0] ? 1'b0 : 1'b1, k);
    write_tx(9'h033, 8'h6C, "R13 restart mid-byte then write"); ref_mem[9'h033] = 8'h6C;
    wait_ready;
    read_seq(9'h033, 1, "R13 readback");
    do_start;
    send_exp(dev_byte(1'b0, 1'b0), 1, "R13 dev");
    for (int i = 0; i < 3; i++) bit_io(1'b1, k);
    do_stop;
    push_exp("R13 mid-byte stop starts no rewrite", 1); poll(1'b0, k); observe(int'(k));
    read_seq(9'h033, 1, "R13 array intact after aborted write");

    chk("scoreboard drained", exp_val_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule